// File: doc/BRIEF.md
# Three-Tap Transmit Feed-Forward Equalizer Code Engine

This block turns a serial binary bit stream into a signed drive code for a segmented transmit DAC. Each bit is read as +1 (for a 1) or -1 (for a 0), and the code is the sum of three programmable tap weights. One tap looks one bit ahead (pre-cursor), one looks at the current bit (main) and one looks one bit back (post-cursor). Since every data value is ±1, each tap adds or subtracts its weight and no multiplier is needed. The result is clamped to the symmetric code range of one weight word.

The weights are written through a small write port into a staging set. A separate apply write moves the whole staging set into the active set in one step, so the filter never runs with a half-updated mix of weights. From the active set the block also reports, as combinational status, the low-frequency gain (the sum of the taps), the alternating-pattern gain (main minus both side taps) and a flag that is raised when the absolute weights add up to more than full scale. After reset the block passes data straight through: the main tap is at full scale and the side taps are zero.

Top module: `tx_ffe_engine`

## Requirements
- R1: After reset, dout is 0, the active weights are pre=0, main=FS and post=0 with FS = 2^(WGT_W-1)-1 (31 by default), so dc_gain = nyq_gain = FS and config_error = 0.
- R2: After each rising edge, dout equals sat(w_pre·s(din) + w_main·s(d1) + w_post·s(d2)). Here s(1)=+1 and s(0)=-1, din is the bit sampled at that edge, d1 is the bit from the edge before and d2 is the bit from two edges before.
- R3: Latency: a bit on din is the pre-cursor input at the edge that samples it and the main-cursor input one edge later, so it reaches dout as the main term two cycles after it is presented. Before the first bit after reset, d1 and d2 read as 0.
- R4: dout is clamped to [-FS, +FS]. Sums above FS give +FS and sums below -FS give -FS.
- R5: A write with wr_addr 0, 1 or 2 loads the staging pre, main or post weight from wr_data (two's complement) and has no effect on dout or on the status outputs. A write with wr_addr 3 copies all three staged weights into the active set at that edge, ignores wr_data, and the new set is first used for the output computed at the next edge.
- R6: dc_gain equals w_pre + w_main + w_post of the active set, as a WGT_W+2 bit signed value.
- R7: nyq_gain equals w_main - w_pre - w_post of the active set, as a WGT_W+2 bit signed value.
- R8: config_error is 1 exactly when |w_pre| + |w_main| + |w_post| > FS for the active set. A weight of -2^(WGT_W-1) counts as 2^(WGT_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Serial data bit (1 = +1, 0 = -1) |
| wr_en | input | 1 | Weight write strobe |
| wr_addr | input | 2 | 0 pre, 1 main, 2 post (staging), 3 apply staged set |
| wr_data | input | WGT_W | Signed weight to stage |
| dout | output | WGT_W | Signed, saturated DAC drive code |
| dc_gain | output | WGT_W+2 | Sum of active weights |
| nyq_gain | output | WGT_W+2 | Main minus side weights |
| config_error | output | 1 | Absolute weight sum exceeds full scale |

## Verification
The bench builds the block with the default WGT_W of 6, so FS is 31 and weights span -32 to +31. At this width the quantized example set (-4, 18, -8) gives a low-frequency gain of 6/31 and an alternating gain of 30/31. The asymmetric -32 corner, whose magnitude exceeds FS by itself, and three full-scale taps that push the sum far past the clamp are also within reach. Random bit streams with interleaved staging and apply writes exercise the rule that weight changes take effect as one set.

// File: rtl/tx_ffe_pkg.sv
package tx_ffe_pkg;
  localparam int NTAPS    = 3;
  localparam int TAP_PRE  = 0;
  localparam int TAP_MAIN = 1;
  localparam int TAP_POST = 2;

  typedef enum logic [1:0] {
    ADDR_PRE   = 2'd0,
    ADDR_MAIN  = 2'd1,
    ADDR_POST  = 2'd2,
    ADDR_APPLY = 2'd3
  } ffe_addr_e;
endpackage

// File: rtl/ffe_weight_bank.sv
module ffe_weight_bank
  import tx_ffe_pkg::*;
#(
  parameter int WGT_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_addr,
  input  logic [WGT_W-1:0]             wr_data,
  output logic [NTAPS-1:0][WGT_W-1:0]  act_o
);
  localparam logic [WGT_W-1:0] FS_CODE = WGT_W'((1 << (WGT_W-1)) - 1);
  localparam logic [NTAPS-1:0][WGT_W-1:0] RST_SET = {WGT_W'(0), FS_CODE, WGT_W'(0)};

  logic [NTAPS-1:0][WGT_W-1:0] stg_q, stg_d, act_q;
  logic                        stg_en, act_en;

  always_comb begin
    stg_d  = stg_q;
    stg_en = 1'b0;
    act_en = 1'b0;
    if (wr_en) begin
      case (ffe_addr_e'(wr_addr))
        ADDR_PRE:   begin stg_d[TAP_PRE]  = wr_data; stg_en = 1'b1; end
        ADDR_MAIN:  begin stg_d[TAP_MAIN] = wr_data; stg_en = 1'b1; end
        ADDR_POST:  begin stg_d[TAP_POST] = wr_data; stg_en = 1'b1; end
        default:    act_en = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= RST_SET;
    end else if (stg_en) begin
      stg_q <= stg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= RST_SET;
    end else if (act_en) begin
      act_q <= stg_q;
    end
  end

  assign act_o = act_q;

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == ADDR_APPLY) |=> $stable(act_q)); // R5
  AST_ACT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_APPLY) |=> (act_q == $past(stg_q))); // R5
endmodule

// File: rtl/ffe_fir_core.sv
module ffe_fir_core
  import tx_ffe_pkg::*;
#(
  parameter int WGT_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         din,
  input  logic [NTAPS-1:0][WGT_W-1:0]  w_i,
  output logic signed [WGT_W-1:0]      dout_o
);
  localparam int SW = WGT_W + 2;
  localparam logic signed [SW-1:0] FS_X  = SW'((1 << (WGT_W-1)) - 1);
  localparam logic signed [SW-1:0] NFS_X = -FS_X;

  logic [1:0]                hist_q, hist_d;
  logic [NTAPS-1:0]          tap_bit;
  logic signed [SW-1:0]      term [NTAPS];
  logic signed [SW-1:0]      acc;
  logic signed [WGT_W-1:0]   dout_d, dout_q;

  assign hist_d  = {hist_q[0], din};
  assign tap_bit = {hist_q[1], hist_q[0], din};

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    logic signed [SW-1:0] wext;
    assign wext    = {{(SW-WGT_W){w_i[g][WGT_W-1]}}, w_i[g]};
    assign term[g] = tap_bit[g] ? wext : -wext;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NTAPS; i++) begin
      acc = acc + term[i];
    end
    if (acc > FS_X) begin
      dout_d = FS_X[WGT_W-1:0];
    end else if (acc < NFS_X) begin
      dout_d = NFS_X[WGT_W-1:0];
    end else begin
      dout_d = acc[WGT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      dout_q <= '0;
    end else begin
      hist_q <= hist_d;
      dout_q <= dout_d;
    end
  end

  assign dout_o = dout_q;

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_q <= FS_X) && (dout_q >= NFS_X)); // R4
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    hist_q[1] == $past(hist_q[0])); // R3
endmodule

// File: rtl/ffe_gain_mon.sv
module ffe_gain_mon
  import tx_ffe_pkg::*;
#(
  parameter int WGT_W = 6
) (
  input  logic [NTAPS-1:0][WGT_W-1:0]  w_i,
  output logic signed [WGT_W+1:0]      dc_o,
  output logic signed [WGT_W+1:0]      nyq_o,
  output logic                         err_o
);
  localparam int SW = WGT_W + 2;
  localparam logic signed [SW-1:0] FS_X = SW'((1 << (WGT_W-1)) - 1);

  logic signed [SW-1:0] wx  [NTAPS];
  logic signed [SW-1:0] mag [NTAPS];
  logic signed [SW-1:0] mag_sum;

  for (genvar g = 0; g < NTAPS; g++) begin : g_mag
    assign wx[g]  = {{(SW-WGT_W){w_i[g][WGT_W-1]}}, w_i[g]};
    assign mag[g] = w_i[g][WGT_W-1] ? -wx[g] : wx[g];
  end

  always_comb begin
    dc_o    = '0;
    mag_sum = '0;
    for (int i = 0; i < NTAPS; i++) begin
      dc_o    = dc_o + wx[i];
      mag_sum = mag_sum + mag[i];
    end
    nyq_o = wx[TAP_MAIN] - wx[TAP_PRE] - wx[TAP_POST];
    err_o = mag_sum > FS_X;
  end
endmodule

// File: rtl/tx_ffe_engine.sv
module tx_ffe_engine
  import tx_ffe_pkg::*;
#(
  parameter int WGT_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    din,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [WGT_W-1:0]        wr_data,
  output logic signed [WGT_W-1:0] dout,
  output logic signed [WGT_W+1:0] dc_gain,
  output logic signed [WGT_W+1:0] nyq_gain,
  output logic                    config_error
);
  localparam int SW = WGT_W + 2;
  localparam logic signed [SW-1:0] FS_X = SW'((1 << (WGT_W-1)) - 1);

  logic [1:0]                  rst_sync_q;
  logic                        rst_int_n;
  logic [NTAPS-1:0][WGT_W-1:0] act_w;
  logic signed [SW-1:0]        main_x2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  ffe_weight_bank #(.WGT_W(WGT_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .act_o   (act_w)
  );

  ffe_fir_core #(.WGT_W(WGT_W)) u_fir (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .din    (din),
    .w_i    (act_w),
    .dout_o (dout)
  );

  ffe_gain_mon #(.WGT_W(WGT_W)) u_mon (
    .w_i   (act_w),
    .dc_o  (dc_gain),
    .nyq_o (nyq_gain),
    .err_o (config_error)
  );

  assign main_x2 = SW'({{(SW-WGT_W){act_w[TAP_MAIN][WGT_W-1]}}, act_w[TAP_MAIN]} <<< 1);

  AST_CFG_BOUND: assert property (@(posedge clk) disable iff (!rst_int_n)
    !config_error |-> ((dc_gain <= FS_X) && (dc_gain >= -FS_X)
                       && (nyq_gain <= FS_X) && (nyq_gain >= -FS_X))); // R8
  AST_GAIN_MAIN: assert property (@(posedge clk) disable iff (!rst_int_n)
    SW'(dc_gain + nyq_gain) == main_x2); // R6
endmodule

// File: tb/sim_tx_ffe_engine.sv
module sim_tx_ffe_engine;
  localparam int W  = 6;
  localparam int FS = (1 << (W-1)) - 1;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                din;
  logic                wr_en;
  logic [1:0]          wr_addr;
  logic [W-1:0]        wr_data;
  logic signed [W-1:0] dout;
  logic signed [W+1:0] dc_gain;
  logic signed [W+1:0] nyq_gain;
  logic                config_error;

  int checks   = 0;
  int failures = 0;
  int mw [3];
  int sw [3];
  bit h0, h1;

  always #5 clk = ~clk;

  tx_ffe_engine #(.WGT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dout(dout), .dc_gain(dc_gain), .nyq_gain(nyq_gain),
    .config_error(config_error)
  );

  function automatic int term(int w, bit b);
    return b ? w : -w;
  endfunction

  function automatic int sat(int s);
    if (s > FS) return FS;
    if (s < -FS) return -FS;
    return s;
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_status();
    chk(int'(dc_gain), mw[0] + mw[1] + mw[2], "R6 dc_gain");
    chk(int'(nyq_gain), mw[1] - mw[0] - mw[2], "R7 nyq_gain");
    chk(int'(config_error), (iabs(mw[0]) + iabs(mw[1]) + iabs(mw[2]) > FS) ? 1 : 0, "R8 config_error");
  endtask

  task automatic step(bit b, bit we, int a, int d, string tag);
    int exp;
    din     = b;
    wr_en   = we;
    wr_addr = 2'(a);
    wr_data = W'(d);
    exp = sat(term(mw[0], b) + term(mw[1], h0) + term(mw[2], h1));
    @(posedge clk);
    h1 = h0;
    h0 = b;
    if (we) begin
      if (a < 3) sw[a] = d;
      else for (int i = 0; i < 3; i++) mw[i] = sw[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk(int'(dout), exp, tag);
    chk_status();
  endtask

  task automatic load_set(int p, int m, int q);
    step(1'b0, 1'b1, 0, p, "R5 stage pre");
    step(1'b0, 1'b1, 1, m, "R5 stage main");
    step(1'b0, 1'b1, 2, q, "R5 stage post");
    step(1'b0, 1'b1, 3, 21, "R5 apply");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; din = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mw = '{0, FS, 0};
    sw = '{0, FS, 0};
    h0 = 1'b0; h1 = 1'b0;
    // R1 reset state
    chk(int'(dout), 0, "R1 dout");
    chk(int'(dc_gain), FS, "R1 dc_gain");
    chk(int'(nyq_gain), FS, "R1 nyq_gain");
    chk(int'(config_error), 0, "R1 config_error");

    // R3 lone pulse through the pass-through setting
    step(1'b0, 1'b0, 0, 0, "R3 before");
    step(1'b1, 1'b0, 0, 0, "R3 pulse in");
    chk(int'(dout), -FS, "R3 not yet main");
    step(1'b0, 1'b0, 0, 0, "R3 main");
    chk(int'(dout), FS, "R3 two-cycle main");
    step(1'b0, 1'b0, 0, 0, "R3 after");

    // R5 staged writes must not disturb output or status until apply
    step(1'b1, 1'b1, 0, -4, "R5 stage only");
    step(1'b1, 1'b1, 1, 18, "R5 stage only");
    chk(int'(dc_gain), FS, "R5 status unchanged");
    step(1'b1, 1'b1, 2, -8, "R5 stage only");
    step(1'b1, 1'b1, 3, 5, "R5 apply edge uses old set");
    step(1'b1, 1'b0, 0, 0, "R5 new set active");

    // R2 low-frequency and alternating patterns with example weights
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 0, 0, "R2 all ones");
    chk(int'(dout), 6, "R2 dc settle");
    chk(int'(dc_gain), 6, "R6 example dc");
    chk(int'(nyq_gain), 30, "R7 example nyq");
    for (int i = 0; i < 8; i++) step(1'(i & 1), 1'b0, 0, 0, "R2 alternating");
    chk(iabs(int'(dout)), 30, "R2 alternating magnitude");

    // R4 saturation with three full-scale taps
    load_set(FS, FS, FS);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 0, 0, "R4 clamp high");
    chk(int'(dout), FS, "R4 high");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, 0, "R4 clamp low");
    chk(int'(dout), -FS, "R4 low");
    chk(int'(config_error), 1, "R8 overload");

    // R8 asymmetric most-negative main weight
    load_set(0, -(FS + 1), 0);
    chk(int'(config_error), 1, "R8 min code");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 0, 0, "R4 min code clamp");

    // Random bits with interleaved writes and applies
    for (int n = 0; n < 3000; n++) begin
      bit b  = 1'($urandom_range(1));
      bit we = ($urandom_range(3) == 0);
      int a  = int'($urandom_range(3));
      int d  = int'($urandom_range(2 * FS + 1)) - (FS + 1);
      step(b, we, a, d, "R2 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule